// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits beside a byte-wide flash device and watches every qualified write cycle that reaches it. It recognises the multi-write unlock sequences that software uses to issue device commands. Each sequence is keyed on both the 15-bit address and the 8-bit data of every write. When a sequence completes, the block raises a single-cycle command pulse. The pulse goes to the controller that carries out protection changes, chip erase or identification reads.

A short sequence has three writes: the two key writes, then a command byte at the command address. The command byte chooses one of four outcomes: protection enable (which also lets the page load that follows proceed), product-ID entry, product-ID exit, or a switch to the long form. The long form adds a second pair of key writes and then a final command byte. That byte chooses protection disable, chip erase or an alternate product-ID entry. The block keeps a sticky protection flag and an identification-mode flag. After chip erase and after any identification entry or exit, it holds `busy` for a pause whose length is a parameter in clock cycles. While `busy` is high it ignores every write.

The sequencer states are `ST_IDLE`, `ST_KEY1` (first key seen), `ST_KEY2` (second key seen), `ST_EXT0` (long form chosen), `ST_EXT1` (third key seen) and `ST_EXT2` (fourth key seen). The transitions are:
- IDLE→KEY1 on AA at 5555.
- KEY1→KEY2 and EXT1→EXT2 on 55 at 2AAA.
- EXT0→EXT1 on AA at 5555.
- KEY2→EXT0 on 80 at 5555.
- KEY2→IDLE on A0, 90 or F0 at 5555, each firing its command.
- EXT2→IDLE on 20, 10 or 60 at 5555, each firing its command.
- Restart: any other accepted write goes to KEY1 if it is AA at 5555, and to IDLE otherwise. EXT0 always goes to IDLE on a mismatch.

Top module: `fcmd_unlock_top`

## Requirements
- R1: After reset all five command pulses are low, `prot_flag` is 0, `id_flag` is 0 and `busy` is 0.
- R2: Writes AA@5555, 55@2AAA, A0@5555 raise `cmd_prot_load` in the cycle after the third write, and `prot_flag` becomes 1 in that same cycle.
- R3: Writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555 raise `cmd_prot_off` in the cycle after the sixth write, and `prot_flag` becomes 0 in that same cycle.
- R4: The same six-write form ending in 10@5555 raises `cmd_erase`. `busy` is then high for exactly ERASE_PAUSE_CYC cycles, starting with the pulse cycle.
- R5: A three-write form ending in 90@5555, or the six-write form ending in 60@5555, raises `cmd_id_enter` and sets `id_flag`. `busy` is then high for exactly ID_PAUSE_CYC cycles.
- R6: A three-write form ending in F0@5555 raises `cmd_id_exit` and clears `id_flag`. `busy` is then high for exactly ID_PAUSE_CYC cycles.
- R7: Address matching uses all 15 address bits. A key or command byte at any other address does not advance the sequence.
- R8: A write that does not match the expected address/data pair returns the sequencer to idle. If that write is AA@5555, it counts as a new first key write.
- R9: A write presented while `busy` is high is ignored. It produces no pulse and does not advance the sequence.
- R10: `prot_flag` changes only on a completed enable (R2) or disable (R3) sequence. Erase and identification commands leave it unchanged.
- R11: Each command pulse lasts one cycle, and at most one pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Qualified write strobe, one cycle per bus write |
| wr_addr | input | 15 | Write address |
| wr_data | input | 8 | Write data |
| cmd_prot_load | output | 1 | Pulse: protection enabled, page load permitted |
| cmd_prot_off | output | 1 | Pulse: protection disabled |
| cmd_erase | output | 1 | Pulse: chip erase requested |
| cmd_id_enter | output | 1 | Pulse: product-ID mode entered (either form) |
| cmd_id_exit | output | 1 | Pulse: product-ID mode left |
| prot_flag | output | 1 | Sticky protection state |
| id_flag | output | 1 | Product-ID mode state |
| busy | output | 1 | Pause in progress; writes are ignored |

## Verification
The properties assume that reset is applied from the first edge and that `wr_stb` stays low during reset. They also assume that every bus write appears as `wr_stb` high for exactly one sampled edge, with address and data valid on that edge. The bench changes all inputs on the falling clock edge and holds `wr_stb` low through reset. Its random mix is weighted toward key and command writes, with idle cycles in between, so that complete sequences, broken sequences and writes inside a pause all occur while the inputs stay within those assumptions.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADR_CMD = 15'h5555;
    localparam logic [ADDR_W-1:0] ADR_ALT = 15'h2AAA;

    localparam logic [DATA_W-1:0] K_FIRST  = 8'hAA;
    localparam logic [DATA_W-1:0] K_SECOND = 8'h55;
    localparam logic [DATA_W-1:0] K_PROT   = 8'hA0;
    localparam logic [DATA_W-1:0] K_EXT    = 8'h80;
    localparam logic [DATA_W-1:0] K_IDIN   = 8'h90;
    localparam logic [DATA_W-1:0] K_IDOUT  = 8'hF0;
    localparam logic [DATA_W-1:0] K_UNPROT = 8'h20;
    localparam logic [DATA_W-1:0] K_ERASE  = 8'h10;
    localparam logic [DATA_W-1:0] K_IDALT  = 8'h60;

    localparam int NCMD     = 5;
    localparam int C_PROT   = 0;
    localparam int C_UNPROT = 1;
    localparam int C_ERASE  = 2;
    localparam int C_IDIN   = 3;
    localparam int C_IDOUT  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_EXT0,
        ST_EXT1,
        ST_EXT2
    } seq_state_t;

endpackage

// File: rtl/fcmd_match.sv
module fcmd_match
    import fcmd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              hit_first,
    output logic              hit_second,
    output logic              at_cmd
);

    always_comb begin
        at_cmd     = (addr == ADR_CMD);
        hit_first  = at_cmd && (data == K_FIRST);
        hit_second = (addr == ADR_ALT) && (data == K_SECOND);
    end

endmodule

// File: rtl/fcmd_seq_fsm.sv
module fcmd_seq_fsm
    import fcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_stb,
    input  logic              hit_first,
    input  logic              hit_second,
    input  logic              at_cmd,
    input  logic [DATA_W-1:0] data,
    output logic [NCMD-1:0]   fire,
    output logic [NCMD-1:0]   pulse
);

    seq_state_t state_q;
    seq_state_t state_d;
    seq_state_t restart;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and command decode
    always_comb begin
        state_d = state_q;
        fire    = '0;
        restart = hit_first ? ST_KEY1 : ST_IDLE;
        if (acc_stb) begin
            unique case (state_q)
                ST_IDLE: state_d = restart;
                ST_KEY1: state_d = hit_second ? ST_KEY2 : restart;
                ST_KEY2: begin
                    state_d = restart;
                    if (at_cmd) begin
                        if (data == K_PROT) begin
                            fire[C_PROT] = 1'b1;
                            state_d      = ST_IDLE;
                        end else if (data == K_IDIN) begin
                            fire[C_IDIN] = 1'b1;
                            state_d      = ST_IDLE;
                        end else if (data == K_IDOUT) begin
                            fire[C_IDOUT] = 1'b1;
                            state_d       = ST_IDLE;
                        end else if (data == K_EXT) begin
                            state_d = ST_EXT0;
                        end
                    end
                end
                ST_EXT0: state_d = hit_first ? ST_EXT1 : ST_IDLE;
                ST_EXT1: state_d = hit_second ? ST_EXT2 : restart;
                ST_EXT2: begin
                    state_d = restart;
                    if (at_cmd) begin
                        if (data == K_UNPROT) begin
                            fire[C_UNPROT] = 1'b1;
                            state_d        = ST_IDLE;
                        end else if (data == K_ERASE) begin
                            fire[C_ERASE] = 1'b1;
                            state_d       = ST_IDLE;
                        end else if (data == K_IDALT) begin
                            fire[C_IDIN] = 1'b1;
                            state_d      = ST_IDLE;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // registered one-cycle command pulses
    for (genvar g = 0; g < NCMD; g++) begin : g_pulse
        logic q;
        always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= fire[g];
        end
        assign pulse[g] = q;
    end

endmodule

// File: rtl/fcmd_mode_flags.sv
module fcmd_mode_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_prot,
    input  logic clr_prot,
    input  logic set_id,
    input  logic clr_id,
    output logic prot_q,
    output logic id_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q <= 1'b0;
            id_q   <= 1'b0;
        end else begin
            if (set_prot)      prot_q <= 1'b1;
            else if (clr_prot) prot_q <= 1'b0;
            if (set_id)        id_q   <= 1'b1;
            else if (clr_id)   id_q   <= 1'b0;
        end
    end

endmodule

// File: rtl/fcmd_pause_timer.sv
module fcmd_pause_timer #(
    parameter int ID_PAUSE_CYC    = 1000,
    parameter int ERASE_PAUSE_CYC = 5000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_id,
    input  logic start_erase,
    output logic busy
);

    localparam int MAXP = (ERASE_PAUSE_CYC > ID_PAUSE_CYC) ? ERASE_PAUSE_CYC : ID_PAUSE_CYC;
    localparam int CW   = $clog2(MAXP + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (start_erase)  cnt_q <= CW'(ERASE_PAUSE_CYC);
        else if (start_id)     cnt_q <= CW'(ID_PAUSE_CYC);
        else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/fcmd_unlock_top.sv
module fcmd_unlock_top
    import fcmd_pkg::*;
#(
    parameter int ID_PAUSE_CYC    = 1000,
    parameter int ERASE_PAUSE_CYC = 5000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              cmd_prot_load,
    output logic              cmd_prot_off,
    output logic              cmd_erase,
    output logic              cmd_id_enter,
    output logic              cmd_id_exit,
    output logic              prot_flag,
    output logic              id_flag,
    output logic              busy
);

    logic            hit_first, hit_second, at_cmd;
    logic            acc_stb;
    logic [NCMD-1:0] fire, pulse;

    assign acc_stb = wr_stb && !busy;

    fcmd_match u_match (
        .addr       (wr_addr),
        .data       (wr_data),
        .hit_first  (hit_first),
        .hit_second (hit_second),
        .at_cmd     (at_cmd)
    );

    fcmd_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_stb    (acc_stb),
        .hit_first  (hit_first),
        .hit_second (hit_second),
        .at_cmd     (at_cmd),
        .data       (wr_data),
        .fire       (fire),
        .pulse      (pulse)
    );

    fcmd_mode_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_prot (fire[C_PROT]),
        .clr_prot (fire[C_UNPROT]),
        .set_id   (fire[C_IDIN]),
        .clr_id   (fire[C_IDOUT]),
        .prot_q   (prot_flag),
        .id_q     (id_flag)
    );

    fcmd_pause_timer #(
        .ID_PAUSE_CYC    (ID_PAUSE_CYC),
        .ERASE_PAUSE_CYC (ERASE_PAUSE_CYC)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_id    (fire[C_IDIN] | fire[C_IDOUT]),
        .start_erase (fire[C_ERASE]),
        .busy        (busy)
    );

    assign cmd_prot_load = pulse[C_PROT];
    assign cmd_prot_off  = pulse[C_UNPROT];
    assign cmd_erase     = pulse[C_ERASE];
    assign cmd_id_enter  = pulse[C_IDIN];
    assign cmd_id_exit   = pulse[C_IDOUT];

endmodule

// File: rtl/fcmd_unlock_chk.sv
module fcmd_unlock_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_stb,
    input logic cmd_prot_load,
    input logic cmd_prot_off,
    input logic cmd_erase,
    input logic cmd_id_enter,
    input logic cmd_id_exit,
    input logic prot_flag,
    input logic id_flag,
    input logic busy
);

    logic [4:0] pv;
    assign pv = {cmd_id_exit, cmd_id_enter, cmd_erase, cmd_prot_off, cmd_prot_load};

    a_r11_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pv));

    a_r11_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (pv != 5'd0) |=> (pv == 5'd0));

    a_r2_prot_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_flag) |-> cmd_prot_load);

    a_r3_prot_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_flag) |-> cmd_prot_off);

    a_r4_erase_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_erase |-> busy);

    a_r5_id_enter: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_id_enter |-> (busy && id_flag));

    a_r6_id_exit: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_id_exit |-> (busy && !id_flag));

    a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_stb) |=> (pv == 5'd0));

    a_r8_pulse_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (pv != 5'd0) |-> $past(wr_stb));

endmodule

bind fcmd_unlock_top fcmd_unlock_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_stb        (wr_stb),
    .cmd_prot_load (cmd_prot_load),
    .cmd_prot_off  (cmd_prot_off),
    .cmd_erase     (cmd_erase),
    .cmd_id_enter  (cmd_id_enter),
    .cmd_id_exit   (cmd_id_exit),
    .prot_flag     (prot_flag),
    .id_flag       (id_flag),
    .busy          (busy)
);

// File: tb/fcmd_unlock_top_tb_top.sv
module fcmd_unlock_top_tb_top;

    localparam int ID_P = 6;
    localparam int ER_P = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        cmd_prot_load, cmd_prot_off, cmd_erase, cmd_id_enter, cmd_id_exit;
    logic        prot_flag, id_flag, busy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // model state
    int         m_st = 0;
    int         m_bc = 0;
    bit         m_prot = 0;
    bit         m_id = 0;
    logic [4:0] exp_p = '0;

    always #5 clk = ~clk;

    fcmd_unlock_top #(.ID_PAUSE_CYC(ID_P), .ERASE_PAUSE_CYC(ER_P)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd_prot_load(cmd_prot_load), .cmd_prot_off(cmd_prot_off), .cmd_erase(cmd_erase),
        .cmd_id_enter(cmd_id_enter), .cmd_id_exit(cmd_id_exit),
        .prot_flag(prot_flag), .id_flag(id_flag), .busy(busy)
    );

    function automatic logic [4:0] pvec();
        return {cmd_id_exit, cmd_id_enter, cmd_erase, cmd_prot_off, cmd_prot_load};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // expected behaviour after one clock edge, from the requirements
    task automatic model_step(input logic s, input logic [14:0] a, input logic [7:0] d);
        bit k1, k2, c;
        int nx;
        k1 = (a == 15'h5555) && (d == 8'hAA);
        k2 = (a == 15'h2AAA) && (d == 8'h55);
        c  = (a == 15'h5555);
        exp_p = '0;
        nx = m_st;
        if (s && m_bc == 0) begin
            case (m_st)
                0: nx = k1 ? 1 : 0;
                1: nx = k2 ? 2 : (k1 ? 1 : 0);
                2: begin
                    nx = k1 ? 1 : 0;
                    if (c) begin
                        if (d == 8'hA0)      begin exp_p[0] = 1; nx = 0; end
                        else if (d == 8'h90) begin exp_p[3] = 1; nx = 0; end
                        else if (d == 8'hF0) begin exp_p[4] = 1; nx = 0; end
                        else if (d == 8'h80) nx = 3;
                    end
                end
                3: nx = k1 ? 4 : 0;
                4: nx = k2 ? 5 : (k1 ? 1 : 0);
                5: begin
                    nx = k1 ? 1 : 0;
                    if (c) begin
                        if (d == 8'h20)      begin exp_p[1] = 1; nx = 0; end
                        else if (d == 8'h10) begin exp_p[2] = 1; nx = 0; end
                        else if (d == 8'h60) begin exp_p[3] = 1; nx = 0; end
                    end
                end
                default: nx = 0;
            endcase
        end
        m_st = nx;
        if (exp_p[0]) m_prot = 1;
        if (exp_p[1]) m_prot = 0;
        if (exp_p[3]) m_id = 1;
        if (exp_p[4]) m_id = 0;
        if (exp_p[2])                 m_bc = ER_P;
        else if (exp_p[3] | exp_p[4]) m_bc = ID_P;
        else if (m_bc > 0)            m_bc--;
    endtask

    // one cycle: drive at negedge, sample at next negedge
    task automatic tick(input logic s, input logic [14:0] a, input logic [7:0] d);
        wr_stb = s; wr_addr = a; wr_data = d;
        model_step(s, a, d);
        @(posedge clk);
        @(negedge clk);
        wr_stb = 1'b0;
        chk("R11 pulse vector", 32'(pvec()), 32'(exp_p));
        chk("R10 protection flag", 32'(prot_flag), 32'(m_prot));
        chk("R5 id flag", 32'(id_flag), 32'(m_id));
        chk("R9 busy", 32'(busy), 32'(m_bc != 0));
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d);
        tick(1'b1, a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 15'h0, 8'h0);
    endtask

    task automatic short_seq(input logic [7:0] c);
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, c);
    endtask

    task automatic long_seq(input logic [7:0] c);
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h80);
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, c);
    endtask

    task automatic wait_idle();
        while (busy) idle(1);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int bcnt;
        void'($urandom(32'h0000_5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 pulses after reset", 32'(pvec()), 0);
        chk("R1 prot_flag after reset", 32'(prot_flag), 0);
        chk("R1 id_flag after reset", 32'(id_flag), 0);
        chk("R1 busy after reset", 32'(busy), 0);

        // R2 enable
        short_seq(8'hA0);
        chk("R2 prot_load pulse", 32'(cmd_prot_load), 1);
        chk("R2 prot_flag set", 32'(prot_flag), 1);
        idle(1);
        chk("R11 pulse dropped", 32'(cmd_prot_load), 0);

        // R10 erase leaves protection; R4 erase pause length
        long_seq(8'h10);
        chk("R4 erase pulse", 32'(cmd_erase), 1);
        chk("R10 prot kept after erase", 32'(prot_flag), 1);
        bcnt = 0;
        while (busy) begin bcnt++; idle(1); end
        chk("R4 busy length", 32'(bcnt), 32'(ER_P));

        // R9 writes during busy ignored
        long_seq(8'h10);
        long_seq(8'h20);
        chk("R9 no disable while busy", 32'(prot_flag), 1);
        wait_idle();

        // R3 disable
        long_seq(8'h20);
        chk("R3 prot_off pulse", 32'(cmd_prot_off), 1);
        chk("R3 prot_flag cleared", 32'(prot_flag), 0);

        // R5 entry, R6 exit, R5 alternate entry
        short_seq(8'h90);
        chk("R5 id_enter pulse", 32'(cmd_id_enter), 1);
        bcnt = 0;
        while (busy) begin bcnt++; idle(1); end
        chk("R5 id busy length", 32'(bcnt), 32'(ID_P));
        short_seq(8'hF0);
        chk("R6 id_exit pulse", 32'(cmd_id_exit), 1);
        chk("R6 id_flag cleared", 32'(id_flag), 0);
        wait_idle();
        long_seq(8'h60);
        chk("R5 alternate entry", 32'(id_flag), 1);
        chk("R10 prot unchanged by id", 32'(prot_flag), 0);
        wait_idle();

        // R7 near-miss addresses
        wr(15'h5554, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hA0);
        chk("R7 wrong first address", 32'(prot_flag), 0);
        wr(15'h5555, 8'hAA); wr(15'h6AAA, 8'h55); wr(15'h5555, 8'hA0);
        chk("R7 wrong second address", 32'(prot_flag), 0);
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h1555, 8'hA0);
        chk("R7 wrong command address", 32'(prot_flag), 0);

        // R8 restart on AA@5555, plain reset on others
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hAA);
        wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hA0);
        chk("R8 restart sequence", 32'(cmd_prot_load), 1);
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h13); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h20);
        chk("R8 broken sequence", 32'(prot_flag), 1);
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h80);
        wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h20);
        chk("R8 broken long form", 32'(prot_flag), 1);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 16);
            case (r)
                0, 1, 2, 3: wr(15'h5555, 8'hAA);
                4, 5, 6:    wr(15'h2AAA, 8'h55);
                7:  wr(15'h5555, 8'hA0);
                8:  wr(15'h5555, 8'h80);
                9:  wr(15'h5555, 8'h90);
                10: wr(15'h5555, 8'hF0);
                11: wr(15'h5555, 8'h20);
                12: wr(15'h5555, 8'h10);
                13: wr(15'h5555, 8'h60);
                14: wr(15'($urandom), 8'($urandom));
                default: idle(1);
            endcase
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule